// File: doc/BRIEF.md
# Mode-1 SPI Byte Slave with Polled Status

This block is an SPI slave that exchanges one byte per select window with an external master. It works in the system clock domain. SCK, the active-low select and MOSI are brought in through two-flop synchronizers, and SCK edges are found by comparing successive synchronized samples. The serial format is fixed: SCK idles low, each bit is launched on a rising SCK edge and captured on the falling edge that follows, and the most significant bit goes first.

A small CPU port polls the block. On reads, address 0 returns the last received byte and address 1 returns the status flags. On writes, address 0 queues the byte to send and address 1 clears the overrun flag. The master may toggle SCK while select is high, for example a lone pulse before or after a transfer. The slave ignores these pulses. It keeps no timeout, so bit periods of any length work.

Top module: `spi1_slave`

## Requirements
- R1: After reset the status reads rx_ready=0, tx_ready=1 and overrun=0. Status is at address 1: bit 0 is rx_ready, bit 1 is tx_ready, bit 2 is overrun, and bits 7:3 read 0. After reset, miso_o=0 and miso_oe_o=0.
- R2: While select is low, MOSI is captured on each falling SCK edge, MSB first. After the 8th falling edge the byte can be read at address 0 and rx_ready is 1.
- R3: The byte written at address 0 before a transfer is driven on miso_o MSB first. Bit 7 appears after the first rising SCK edge once select is low, and each later rising edge presents the next bit.
- R4: A write to address 0 clears tx_ready. tx_ready returns to 1 when select falls and the queued byte is taken for sending.
- R5: If no byte was written since the previous transfer started, the slave sends 0x00.
- R6: A CPU read of address 0 clears rx_ready.
- R7: If a byte completes while rx_ready is still 1, overrun is set and stays set, and the new byte replaces the old one at address 0. Writing address 1 with bit 2 set clears overrun.
- R8: SCK edges while select is high do not shift, count or drive. Such pulses never set rx_ready, and they do not disturb the alignment of the next transfer.
- R9: If select rises before 8 falling edges, the partial byte is discarded and rx_ready stays 0. The next transfer starts from bit 7.
- R10: There is no SCK inactivity timeout. A transfer with a 1000-clock SCK half period works the same as a fast one.
- R11: While select is high, miso_o is 0 and miso_oe_o is 0. While select is low, miso_oe_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck_i | input | 1 | Serial clock from the master (asynchronous) |
| ss_n_i | input | 1 | Active-low select from the master (asynchronous) |
| mosi_i | input | 1 | Serial data from the master |
| miso_o | output | 1 | Serial data to the master |
| miso_oe_o | output | 1 | Drive enable for miso_o, high while selected |
| cpu_addr_i | input | 1 | Register select: 0 data, 1 status |
| cpu_rd_i | input | 1 | Read strobe, one cycle |
| cpu_wr_i | input | 1 | Write strobe, one cycle |
| cpu_wdata_i | input | 8 | Write data |
| cpu_rdata_o | output | 8 | Read data for the addressed register |

## Verification
The bench builds the block with its defaults: an 8-bit frame and two synchronizer stages. At this size every receive value from 0x00 to 0xFF can be driven, each paired with a distinct transmit value, so both shift paths and the flag handshakes are swept in full. Stray select-high pulses are mixed into half the sweep. Separate sequences then cover a missing transmit byte, overrun and its clear, an aborted frame, and a slow SCK.

// File: rtl/spi1_pkg.sv
package spi1_pkg;
    localparam int DATA_W      = 8;
    localparam int SYNC_STAGES = 2;

    typedef enum logic {
        REG_DATA   = 1'b0,
        REG_STATUS = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic overrun;
        logic tx_ready;
        logic rx_ready;
    } status_t;

    localparam int OVR_CLR_BIT = 2;

    function automatic logic [DATA_W-1:0] pack_status(status_t s);
        logic [DATA_W-1:0] v;
        v = '0;
        v[2:0] = s;
        return v;
    endfunction
endpackage

// File: rtl/spi1_sync.sv
module spi1_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] chain [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= RST_VAL;
                else if (g == 0) chain[g] <= d_i;
                else chain[g] <= chain[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/spi1_shifter.sv
module spi1_shifter
    import spi1_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sck_s,
    input  logic                 ss_s,
    input  logic                 mosi_s,
    input  logic [W-1:0]         tx_byte,
    input  logic                 tx_full,
    output logic                 start_o,
    output logic                 done_o,
    output logic [W-1:0]         rx_byte_o,
    output logic                 miso_o,
    output logic                 oe_o,
    output logic [$clog2(W)-1:0] cnt_o
);
    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W-1);

    logic          sck_d, ss_d, rise, fall, active;
    logic [W-1:0]  tx_sh, rx_sh;
    logic [CW-1:0] cnt;
    logic          miso_q;

    assign active  = ~ss_s;
    assign rise    = sck_s & ~sck_d;
    assign fall    = ~sck_s & sck_d;
    assign start_o = ss_d & ~ss_s;
    assign done_o  = active & fall & (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_d     <= 1'b0;
            ss_d      <= 1'b1;
            tx_sh     <= '0;
            rx_sh     <= '0;
            cnt       <= '0;
            miso_q    <= 1'b0;
            rx_byte_o <= '0;
        end else begin
            sck_d <= sck_s;
            ss_d  <= ss_s;
            if (!active) begin
                cnt    <= '0;
                miso_q <= 1'b0;
            end else if (start_o) begin
                tx_sh  <= tx_full ? tx_byte : '0;
                cnt    <= '0;
                miso_q <= 1'b0;
            end else begin
                if (rise) begin
                    miso_q <= tx_sh[W-1];
                    tx_sh  <= {tx_sh[W-2:0], 1'b0};
                end
                if (fall) begin
                    rx_sh <= {rx_sh[W-2:0], mosi_s};
                    cnt   <= (cnt == LAST) ? '0 : cnt + 1'b1;
                    if (cnt == LAST) rx_byte_o <= {rx_sh[W-2:0], mosi_s};
                end
            end
        end
    end

    assign miso_o = active & miso_q;
    assign oe_o   = active;
    assign cnt_o  = cnt;
endmodule

// File: rtl/spi1_regs.sv
module spi1_regs
    import spi1_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic         done_i,
    input  logic [W-1:0] rx_byte_i,
    input  logic         addr_i,
    input  logic         rd_i,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] tx_byte_o,
    output logic         tx_full_o,
    output status_t      status_o,
    output logic [W-1:0] rdata_o
);
    logic rd_data, wr_data, wr_stat;
    logic rx_ready, overrun, tx_full;
    logic [W-1:0] tx_buf;

    assign rd_data = rd_i & (addr_i == REG_DATA);
    assign wr_data = wr_i & (addr_i == REG_DATA);
    assign wr_stat = wr_i & (addr_i == REG_STATUS);

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_ready <= 1'b0;
            overrun  <= 1'b0;
            tx_full  <= 1'b0;
            tx_buf   <= '0;
        end else begin
            if (done_i) rx_ready <= 1'b1;
            else if (rd_data) rx_ready <= 1'b0;

            if (done_i && rx_ready && !rd_data) overrun <= 1'b1;
            else if (wr_stat && wdata_i[OVR_CLR_BIT]) overrun <= 1'b0;

            if (wr_data) begin
                tx_buf  <= wdata_i;
                tx_full <= 1'b1;
            end else if (start_i) begin
                tx_full <= 1'b0;
            end
        end
    end

    assign status_o  = '{overrun: overrun, tx_ready: ~tx_full, rx_ready: rx_ready};
    assign tx_byte_o = tx_buf;
    assign tx_full_o = tx_full;
    assign rdata_o   = (addr_i == REG_STATUS) ? pack_status(status_o) : rx_byte_i;
endmodule

// File: rtl/spi1_slave.sv
module spi1_slave
    import spi1_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sck_i,
    input  logic              ss_n_i,
    input  logic              mosi_i,
    output logic              miso_o,
    output logic              miso_oe_o,
    input  logic              cpu_addr_i,
    input  logic              cpu_rd_i,
    input  logic              cpu_wr_i,
    input  logic [DATA_W-1:0] cpu_wdata_i,
    output logic [DATA_W-1:0] cpu_rdata_o
);
    logic sck_s, ss_s, mosi_s;
    logic start, done, tx_full;
    logic [DATA_W-1:0] rx_byte, tx_byte;
    logic [$clog2(DATA_W)-1:0] bit_cnt;
    status_t status;

    spi1_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
        .clk(clk), .rst(rst),
        .d_i({sck_i, ss_n_i, mosi_i}),
        .q_o({sck_s, ss_s, mosi_s})
    );

    spi1_shifter #(.W(DATA_W)) u_shift (
        .clk(clk), .rst(rst), .sck_s(sck_s), .ss_s(ss_s), .mosi_s(mosi_s),
        .tx_byte(tx_byte), .tx_full(tx_full), .start_o(start), .done_o(done),
        .rx_byte_o(rx_byte), .miso_o(miso_o), .oe_o(miso_oe_o), .cnt_o(bit_cnt)
    );

    spi1_regs #(.W(DATA_W)) u_regs (
        .clk(clk), .rst(rst), .start_i(start), .done_i(done), .rx_byte_i(rx_byte),
        .addr_i(cpu_addr_i), .rd_i(cpu_rd_i), .wr_i(cpu_wr_i), .wdata_i(cpu_wdata_i),
        .tx_byte_o(tx_byte), .tx_full_o(tx_full), .status_o(status), .rdata_o(cpu_rdata_o)
    );
endmodule

// File: rtl/spi1_slave_chk.sv
module spi1_slave_chk
    import spi1_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic ss_s,
    input logic miso_o,
    input logic miso_oe_o,
    input logic cpu_addr_i,
    input logic cpu_rd_i,
    input logic cpu_wr_i,
    input logic [DATA_W-1:0] cpu_wdata_i,
    input logic start,
    input logic done,
    input status_t status,
    input logic [$clog2(DATA_W)-1:0] bit_cnt
);
    // R11: a deselected slave neither drives nor enables MISO
    p_miso_idle_r11: assert property (@(posedge clk) disable iff (rst)
        ss_s |-> (!miso_o && !miso_oe_o));

    // R8: the bit counter stays parked while select is high
    p_no_count_r8: assert property (@(posedge clk) disable iff (rst)
        ss_s |=> (bit_cnt == '0));

    // R6: a data read with no byte completing leaves rx_ready low
    p_rd_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (cpu_rd_i && cpu_addr_i == REG_DATA && !done) |=> !status.rx_ready);

    // R7: overrun holds until an explicit clear
    p_ovr_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (status.overrun && !(cpu_wr_i && cpu_addr_i == REG_STATUS && cpu_wdata_i[OVR_CLR_BIT]))
        |=> status.overrun);

    // R4: a write clears tx_ready, the start of a transfer sets it again
    p_tx_wr_r4: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr_i && cpu_addr_i == REG_DATA) |=> !status.tx_ready);
    p_tx_start_r4: assert property (@(posedge clk) disable iff (rst)
        (start && !(cpu_wr_i && cpu_addr_i == REG_DATA)) |=> status.tx_ready);
endmodule

bind spi1_slave spi1_slave_chk u_chk (
    .clk(clk), .rst(rst), .ss_s(ss_s), .miso_o(miso_o), .miso_oe_o(miso_oe_o),
    .cpu_addr_i(cpu_addr_i), .cpu_rd_i(cpu_rd_i), .cpu_wr_i(cpu_wr_i),
    .cpu_wdata_i(cpu_wdata_i), .start(start), .done(done), .status(status),
    .bit_cnt(bit_cnt)
);

// File: tb/spi1_slave_tb_top.sv
module spi1_slave_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sck = 1'b0, ss_n = 1'b1, mosi = 1'b0;
    logic miso, miso_oe;
    logic addr = 1'b0, rd = 1'b0, wr = 1'b0;
    logic [7:0] wdata = 8'h00, rdata;
    int total = 0, fails = 0;

    always #2.5 clk = ~clk;

    spi1_slave dut_i (
        .clk(clk), .rst(rst), .sck_i(sck), .ss_n_i(ss_n), .mosi_i(mosi),
        .miso_o(miso), .miso_oe_o(miso_oe), .cpu_addr_i(addr), .cpu_rd_i(rd),
        .cpu_wr_i(wr), .cpu_wdata_i(wdata), .cpu_rdata_o(rdata)
    );

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic cpu_write(logic a, logic [7:0] d);
        addr = a; wdata = d; wr = 1'b1;
        wait_cyc(1);
        wr = 1'b0;
        wait_cyc(1);
    endtask

    task automatic cpu_read(logic a, output logic [7:0] d);
        addr = a;
        wait_cyc(1);
        d = rdata;
        rd = 1'b1;
        wait_cyc(1);
        rd = 1'b0;
        wait_cyc(1);
    endtask

    task automatic stray_pulse(int half);
        sck = 1'b1; wait_cyc(half);
        sck = 1'b0; wait_cyc(half);
    endtask

    task automatic frame(logic [7:0] mo, int nbits, int half, bit strays,
                         output logic [7:0] mi);
        mi = 8'h00;
        if (strays) stray_pulse(half);
        ss_n = 1'b0;
        wait_cyc(half);
        for (int i = 0; i < nbits; i++) begin
            sck = 1'b1; mosi = mo[7-i];
            wait_cyc(half);
            mi[7-i] = miso;
            sck = 1'b0;
            wait_cyc(half);
        end
        ss_n = 1'b1;
        wait_cyc(6);
        if (strays) stray_pulse(half);
        wait_cyc(2);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [7:0] d, mi, txb;
        wait_cyc(4);
        rst = 1'b0;
        wait_cyc(4);
        // R1 R11: reset state
        cpu_read(1'b1, d);
        chk(d == 8'h02, "R1 status", d, 8'h02);
        chk(!miso && !miso_oe, "R11 idle miso", {miso, miso_oe}, 0);

        // R2 R3 R4 R6 R8: full sweep of receive values
        for (int b = 0; b < 256; b++) begin
            txb = 8'(b) ^ 8'hA5;
            cpu_write(1'b0, txb);
            cpu_read(1'b1, d);
            chk(d[1] == 1'b0, "R4 tx_ready after write", d[1], 0);
            frame(8'(b), 8, 8, b[0], mi);
            chk(mi == txb, "R3 miso byte", mi, txb);
            cpu_read(1'b1, d);
            chk(d[0] == 1'b1, "R2 rx_ready", d[0], 1);
            chk(d[1] == 1'b1, "R4 tx_ready after start", d[1], 1);
            cpu_read(1'b0, d);
            chk(d == 8'(b), b[0] ? "R8 rx with strays" : "R2 rx byte", d, b);
            cpu_read(1'b1, d);
            chk(d[0] == 1'b0, "R6 rx_ready cleared", d[0], 0);
        end

        // R5: nothing queued sends zero
        frame(8'h3C, 8, 8, 1'b0, mi);
        chk(mi == 8'h00, "R5 empty tx", mi, 0);
        cpu_read(1'b0, d);

        // R7: overrun
        frame(8'h11, 8, 8, 1'b0, mi);
        frame(8'h22, 8, 8, 1'b0, mi);
        cpu_read(1'b1, d);
        chk(d[2] == 1'b1, "R7 overrun set", d[2], 1);
        cpu_read(1'b0, d);
        chk(d == 8'h22, "R7 overwrite", d, 8'h22);
        cpu_read(1'b1, d);
        chk(d[2] == 1'b1, "R7 overrun sticky", d[2], 1);
        cpu_write(1'b1, 8'h04);
        cpu_read(1'b1, d);
        chk(d[2] == 1'b0, "R7 overrun cleared", d[2], 0);

        // R9: aborted frame
        cpu_write(1'b0, 8'h81);
        frame(8'hF0, 5, 8, 1'b0, mi);
        cpu_read(1'b1, d);
        chk(d[0] == 1'b0, "R9 no rx_ready", d[0], 0);
        frame(8'h6B, 8, 8, 1'b0, mi);
        cpu_read(1'b0, d);
        chk(d == 8'h6B, "R9 realign", d, 8'h6B);
        chk(mi == 8'h00, "R9 tx consumed", mi, 0);

        // R8 R11: stray pulses alone
        for (int i = 0; i < 20; i++) begin
            mosi = i[0];
            stray_pulse(8);
            chk(!miso && !miso_oe, "R11 deselected", {miso, miso_oe}, 0);
        end
        cpu_read(1'b1, d);
        chk(d[0] == 1'b0, "R8 strays no rx", d[0], 0);

        // R10: slow clock
        cpu_write(1'b0, 8'hC3);
        frame(8'h5A, 8, 1000, 1'b0, mi);
        chk(mi == 8'hC3, "R10 slow miso", mi, 8'hC3);
        cpu_read(1'b0, d);
        chk(d == 8'h5A, "R10 slow rx", d, 8'h5A);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule